// File: doc/BRIEF.md
# Dual-Target Multiplexed Bus Bridge

This block sits between an 8-bit multiplexed address/data bus and two storage targets. The first is a 64-byte clock register file, made of 14 control and time bytes followed by 50 bytes of user storage. The second is a 4096-byte RAM. Both targets live outside the block. The bridge gives each target an address, a one-cycle write strobe with its data, and a read-data input. For the register file it also gives a per-bit write mask.

Every bus input is asynchronous and passes through a synchronizer into the system clock domain. The data lines travel through the same synchronizer, so that the synchronized data and strobes line up. The register file has an address strobe, an active-low select, a read strobe and a write strobe. The RAM has two rising-edge address strobes, one for the low byte and one for the upper nibble, plus its own read and write strobes. Read data leaves the block on one output bus with one output enable, which stands for the tri-state driver. A power-fail input turns off every access while it is asserted.

Top module: `mbus_bridge`

## Requirements
- R1: A falling edge of `ale` loads `ad_in[5:0]` into `rf_addr`. Bits 7 and 6 of the bus have no effect on `rf_addr`.
- R2: A rising edge of `as0` loads `ad_in[7:0]` into `ram_addr[7:0]`. A rising edge of `as1` loads `ad_in[3:0]` into `ram_addr[11:8]`. Each strobe leaves the other part of the address unchanged.
- R3: A register-file write commits when `wr_n` rises while `cs_n` is low. It produces a single-cycle `rf_we` pulse, and `rf_wdata` holds the bus value last sampled while `wr_n` was low.
- R4: While `cs_n` is high, an `ale` cycle still updates `rf_addr`. No `rf_we` pulse occurs, and `rd_n` low does not raise `ad_oe`.
- R5: A RAM write commits when `wer_n` rises. It produces a single-cycle `ram_we` pulse, with `ram_wdata` holding the last bus value sampled while `wer_n` was low.
- R6: While `rd_n` and `cs_n` are both low, `ad_oe` is 1 and `ad_out` equals `rf_rdata`. While `oer_n` is low, `ad_oe` is 1 and `ad_out` equals `ram_rdata`. Once the active read strobes return high, `ad_oe` returns to 0.
- R7: If a register-file read and a RAM read are active together, `ad_out` carries `rf_rdata`.
- R8: Writes to offsets 12 and 13 produce no `rf_we` pulse, because those bytes are read-only.
- R9: `rf_wmask` marks the bits a write may change. It is 8'h7F for offsets 0 and 10, which protects bit 7 of each. It is 8'hFF for every other writable offset, including user offsets 14 to 63.
- R10: While `pwr_fail` is 1, no `rf_we` or `ram_we` pulse occurs and `ad_oe` stays 0.
- R11: After reset, `ad_oe`, `rf_we`, `ram_we`, `rf_addr` and `ram_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_in | input | 8 | Multiplexed address/data bus, input side |
| ale | input | 1 | Register-file address strobe; the address is taken on its falling edge |
| cs_n | input | 1 | Register-file select, active low |
| rd_n | input | 1 | Register-file read strobe, active low |
| wr_n | input | 1 | Register-file write strobe, active low |
| as0 | input | 1 | RAM low-address strobe; the address byte is taken on its rising edge |
| as1 | input | 1 | RAM high-address strobe; the address nibble is taken on its rising edge |
| oer_n | input | 1 | RAM read strobe, active low |
| wer_n | input | 1 | RAM write strobe, active low |
| pwr_fail | input | 1 | Power not good; blocks all accesses |
| ad_out | output | 8 | Read data for the bus |
| ad_oe | output | 1 | Bus drive enable for `ad_out` |
| rf_addr | output | 6 | Register-file address |
| rf_we | output | 1 | Register-file write pulse |
| rf_wdata | output | 8 | Register-file write data |
| rf_wmask | output | 8 | Register-file per-bit write mask |
| rf_rdata | input | 8 | Register-file read data at `rf_addr` |
| ram_addr | output | 12 | RAM address |
| ram_we | output | 1 | RAM write pulse |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data at `ram_addr` |

## Verification
Two cases are hardest to reach from the ports. One is a RAM address built from strobes that arrive separately, where only the low byte is reloaded. The other is a read in which both read strobes are low at once. The bench reaches the first by strobing `as1` and `as0` with different bus values, then strobing `as0` alone and checking that the upper nibble is kept. It reaches the second by lowering `oer_n` while a register-file read is already active. The cases that must not write are checked by a scoreboard. Such a write (select high, a read-only offset, or power failure) puts no item in the expected queue, so any pulse the design produces anyway is reported as unexpected.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    localparam int DW       = 8;
    localparam int RF_AW    = 6;
    localparam int RAM_LO_W = 8;
    localparam int RAM_HI_W = 4;
    localparam int RAM_AW   = RAM_LO_W + RAM_HI_W;

    // offsets whose behaviour is fixed by the clock core
    localparam logic [RF_AW-1:0] OFS_SECONDS = 6'd0;
    localparam logic [RF_AW-1:0] OFS_CTRL_A  = 6'd10;
    localparam logic [RF_AW-1:0] OFS_FLAGS   = 6'd12;
    localparam logic [RF_AW-1:0] OFS_VALID   = 6'd13;

    // bit index of the synchronized input bundle
    localparam int SI_AD   = 0;
    localparam int SI_PF   = DW;
    localparam int SI_WERN = DW + 1;
    localparam int SI_OERN = DW + 2;
    localparam int SI_AS1  = DW + 3;
    localparam int SI_AS0  = DW + 4;
    localparam int SI_WRN  = DW + 5;
    localparam int SI_RDN  = DW + 6;
    localparam int SI_CSN  = DW + 7;
    localparam int SI_ALE  = DW + 8;
    localparam int SI_W    = DW + 9;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int         W       = 2,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/mbus_wmask.sv
module mbus_wmask
    import mbus_pkg::*;
(
    input  logic [RF_AW-1:0] addr,
    output logic [DW-1:0]    mask
);
    always_comb begin
        unique case (addr)
            OFS_FLAGS, OFS_VALID:    mask = '0;
            OFS_SECONDS, OFS_CTRL_A: mask = {1'b0, {(DW-1){1'b1}}};
            default:                 mask = '1;
        endcase
    end
endmodule

// File: rtl/mbus_bridge.sv
module mbus_bridge
    import mbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     ad_in,
    input  logic              ale,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              as0,
    input  logic              as1,
    input  logic              oer_n,
    input  logic              wer_n,
    input  logic              pwr_fail,
    output logic [DW-1:0]     ad_out,
    output logic              ad_oe,
    output logic [RF_AW-1:0]  rf_addr,
    output logic              rf_we,
    output logic [DW-1:0]     rf_wdata,
    output logic [DW-1:0]     rf_wmask,
    input  logic [DW-1:0]     rf_rdata,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic [DW-1:0]     ram_wdata,
    input  logic [DW-1:0]     ram_rdata
);
    localparam logic [SI_W-1:0] SYNC_RST =
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, {DW{1'b0}}};

    typedef struct packed {
        logic                ale_p;
        logic                wr_p;
        logic                wer_p;
        logic                as0_p;
        logic                as1_p;
        logic [RF_AW-1:0]    rf_addr;
        logic [RAM_LO_W-1:0] ram_lo;
        logic [RAM_HI_W-1:0] ram_hi;
        logic [DW-1:0]       rf_wd;
        logic [DW-1:0]       ram_wd;
        logic [DW-1:0]       wmask;
        logic                rf_we;
        logic                ram_we;
        logic                oe;
        logic [DW-1:0]       dout;
    } state_t;

    localparam state_t STATE_RST = '{
        ale_p: 1'b0, wr_p: 1'b1, wer_p: 1'b1, as0_p: 1'b0, as1_p: 1'b0,
        rf_addr: '0, ram_lo: '0, ram_hi: '0, rf_wd: '0, ram_wd: '0,
        wmask: '0, rf_we: 1'b0, ram_we: 1'b0, oe: 1'b0, dout: '0
    };

    logic [SI_W-1:0] sync_in, sync_out;
    logic [DW-1:0]   ad_s;
    logic            pf_s, ale_s, cs_s, rd_s, wr_s, as0_s, as1_s, oer_s, wer_s;
    logic [DW-1:0]   mask_w;
    state_t          st_d, st_q;

    assign sync_in = {ale, cs_n, rd_n, wr_n, as0, as1, oer_n, wer_n, pwr_fail, ad_in};

    mbus_sync #(.W(SI_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sync_in),
        .dout (sync_out)
    );

    assign ad_s  = sync_out[SI_AD +: DW];
    assign pf_s  = sync_out[SI_PF];
    assign wer_s = sync_out[SI_WERN];
    assign oer_s = sync_out[SI_OERN];
    assign as1_s = sync_out[SI_AS1];
    assign as0_s = sync_out[SI_AS0];
    assign wr_s  = sync_out[SI_WRN];
    assign rd_s  = sync_out[SI_RDN];
    assign cs_s  = sync_out[SI_CSN];
    assign ale_s = sync_out[SI_ALE];

    mbus_wmask i_wmask (
        .addr(st_q.rf_addr),
        .mask(mask_w)
    );

    always_comb begin
        logic rf_rd_act, ram_rd_act;
        st_d        = st_q;
        st_d.ale_p  = ale_s;
        st_d.wr_p   = wr_s;
        st_d.wer_p  = wer_s;
        st_d.as0_p  = as0_s;
        st_d.as1_p  = as1_s;
        st_d.rf_we  = 1'b0;
        st_d.ram_we = 1'b0;

        // address capture, independent paths
        if (st_q.ale_p && !ale_s) st_d.rf_addr = ad_s[RF_AW-1:0];
        if (!st_q.as0_p && as0_s) st_d.ram_lo  = ad_s[RAM_LO_W-1:0];
        if (!st_q.as1_p && as1_s) st_d.ram_hi  = ad_s[RAM_HI_W-1:0];

        // write data follows the bus while the strobe is low
        if (!wr_s)  st_d.rf_wd  = ad_s;
        if (!wer_s) st_d.ram_wd = ad_s;

        // commit on trailing edge of the write strobes
        if (!st_q.wr_p && wr_s && !cs_s && !pf_s && (mask_w != '0)) begin
            st_d.rf_we = 1'b1;
            st_d.wmask = mask_w;
        end
        if (!st_q.wer_p && wer_s && !pf_s) st_d.ram_we = 1'b1;

        // read steering, register file has priority
        rf_rd_act  = !rd_s && !cs_s;
        ram_rd_act = !oer_s;
        st_d.oe    = !pf_s && (rf_rd_act || ram_rd_act);
        st_d.dout  = rf_rd_act ? rf_rdata : ram_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STATE_RST;
        else        st_q <= st_d;
    end

    assign ad_out    = st_q.dout;
    assign ad_oe     = st_q.oe;
    assign rf_addr   = st_q.rf_addr;
    assign rf_we     = st_q.rf_we;
    assign rf_wdata  = st_q.rf_wd;
    assign rf_wmask  = st_q.wmask;
    assign ram_addr  = {st_q.ram_hi, st_q.ram_lo};
    assign ram_we    = st_q.ram_we;
    assign ram_wdata = st_q.ram_wd;
endmodule

// File: rtl/mbus_bridge_chk.sv
module mbus_bridge_chk
    import mbus_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rf_we,
    input logic [RF_AW-1:0] rf_addr,
    input logic [DW-1:0]    rf_wmask,
    input logic             ram_we,
    input logic             ad_oe,
    input logic             pf_s
);
    AST_RF_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we); // R3

    AST_RAM_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we); // R5

    AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_addr != OFS_FLAGS && rf_addr != OFS_VALID)); // R8

    AST_BIT7_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && (rf_addr == OFS_SECONDS || rf_addr == OFS_CTRL_A))
        |-> rf_wmask == 8'h7F); // R9

    AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_addr != OFS_SECONDS && rf_addr != OFS_CTRL_A)
        |-> rf_wmask == 8'hFF); // R9

    AST_PWR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pf_s) |-> (!rf_we && !ram_we && !ad_oe)); // R10
endmodule

bind mbus_bridge mbus_bridge_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rf_we   (rf_we),
    .rf_addr (rf_addr),
    .rf_wmask(rf_wmask),
    .ram_we  (ram_we),
    .ad_oe   (ad_oe),
    .pf_s    (pf_s)
);

// File: tb/test_mbus_bridge.sv
module test_mbus_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ad_in = '0;
    logic        ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic        as0 = 1'b0, as1 = 1'b0, oer_n = 1'b1, wer_n = 1'b1;
    logic        pwr_fail = 1'b0;
    logic [7:0]  ad_out, rf_wdata, rf_wmask, ram_wdata;
    logic        ad_oe, rf_we, ram_we;
    logic [5:0]  rf_addr;
    logic [11:0] ram_addr;
    logic [7:0]  rf_rdata, ram_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [21:0] rf_q [$];   // {addr, data, mask}
    logic [19:0] ram_q [$];  // {addr, data}

    always #2 clk = ~clk;

    // target read models
    assign rf_rdata  = {2'b10, rf_addr};
    assign ram_rdata = ram_addr[7:0] ^ {ram_addr[11:8], 4'h5};

    mbus_bridge i_mbus_bridge (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ale(ale), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .as0(as0), .as1(as1), .oer_n(oer_n),
        .wer_n(wer_n), .pwr_fail(pwr_fail), .ad_out(ad_out), .ad_oe(ad_oe),
        .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .rf_wmask(rf_wmask), .rf_rdata(rf_rdata), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_mask(input logic [5:0] a);
        if (a == 6'd12 || a == 6'd13) return 8'h00;
        if (a == 6'd0 || a == 6'd10) return 8'h7F;
        return 8'hFF;
    endfunction

    task automatic addr_phase(input logic [7:0] v);
        ad_in = v; ale = 1'b1; cyc(3);
        ale = 1'b0; cyc(4);
    endtask

    task automatic rf_write(input logic [7:0] a, input logic [7:0] d, input bit sel);
        addr_phase(a);
        cs_n = !sel; ad_in = d; wr_n = 1'b0; cyc(4);
        wr_n = 1'b1;
        if (sel && !pwr_fail && exp_mask(a[5:0]) != 8'h00)
            rf_q.push_back({a[5:0], d, exp_mask(a[5:0])});
        cyc(5); cs_n = 1'b1; cyc(1);
    endtask

    task automatic ram_strobe(input bit hi, input logic [7:0] v);
        ad_in = v;
        if (hi) as1 = 1'b1; else as0 = 1'b1;
        cyc(4);
        as0 = 1'b0; as1 = 1'b0; cyc(2);
    endtask

    task automatic ram_write(input logic [7:0] d);
        ad_in = d; wer_n = 1'b0; cyc(4);
        wer_n = 1'b1;
        if (!pwr_fail) ram_q.push_back({ram_addr, d});
        cyc(5);
    endtask

    // monitor: pops expected writes when the design produces a pulse
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rf_we) begin
                if (rf_q.size() == 0)
                    chk(0, "R4/R8/R10 unexpected rf_we", {26'd0, rf_addr}, 32'h0);
                else begin
                    logic [21:0] e;
                    e = rf_q.pop_front();
                    chk({rf_addr, rf_wdata, rf_wmask} == e, "R3/R9 rf write",
                        {10'd0, rf_addr, rf_wdata, rf_wmask}, {10'd0, e});
                end
            end
            if (ram_we) begin
                if (ram_q.size() == 0)
                    chk(0, "R10 unexpected ram_we", {20'd0, ram_addr}, 32'h0);
                else begin
                    logic [19:0] e;
                    e = ram_q.pop_front();
                    chk({ram_addr, ram_wdata} == e, "R5 ram write",
                        {12'd0, ram_addr, ram_wdata}, {12'd0, e});
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        cyc(3); rst_n = 1'b1; cyc(1);
        // R11
        chk(!ad_oe && !rf_we && !ram_we, "R11 strobes after reset",
            {ad_oe, rf_we, ram_we}, 0);
        chk(rf_addr == 0 && ram_addr == 0, "R11 addresses after reset",
            {rf_addr, ram_addr}, 0);

        // R1: upper bits ignored
        addr_phase(8'hC5);
        chk(rf_addr == 6'd5, "R1 ale address", rf_addr, 5);
        rf_write(8'hC5, 8'h3C, 1);                  // R3
        rf_write(8'h0A, 8'hFF, 1);                  // R9 ctrl A
        rf_write(8'h00, 8'hAA, 1);                  // R9 seconds
        rf_write(8'h3F, 8'h81, 1);                  // R9 user byte
        rf_write(8'h0E, 8'h42, 1);                  // R9 first user byte
        rf_write(8'h0C, 8'h11, 1);                  // R8
        rf_write(8'h0D, 8'h22, 1);                  // R8
        chk(rf_addr == 6'd13, "R8 address still taken", rf_addr, 13);

        // R4: deselected cycle
        rf_write(8'h1E, 8'h99, 0);
        chk(rf_addr == 6'd30, "R4 address latched with cs high", rf_addr, 30);
        rd_n = 1'b0; cyc(6);
        chk(!ad_oe, "R4 no drive with cs high", ad_oe, 0);
        rd_n = 1'b1; cyc(4);

        // R2: split RAM address
        ram_strobe(1, 8'hAB);
        ram_strobe(0, 8'h34);
        chk(ram_addr == 12'hB34, "R2 ram address", ram_addr, 12'hB34);
        ram_strobe(0, 8'h01);
        chk(ram_addr == 12'hB01, "R2 high nibble kept", ram_addr, 12'hB01);
        ram_write(8'h5A);                           // R5
        ram_strobe(1, 8'hF7);
        chk(ram_addr == 12'h701, "R2 low byte kept", ram_addr, 12'h701);
        ram_write(8'hC3);                           // R5

        // R6: register-file read
        addr_phase(8'h05);
        cs_n = 1'b0; rd_n = 1'b0; cyc(6);
        chk(ad_oe && ad_out == 8'h85, "R6 rf read", {ad_oe, ad_out}, {1'b1, 8'h85});
        // R7: both reads together
        oer_n = 1'b0; cyc(6);
        chk(ad_oe && ad_out == 8'h85, "R7 rf priority", {ad_oe, ad_out}, {1'b1, 8'h85});
        rd_n = 1'b1; cs_n = 1'b1; cyc(6);
        chk(ad_oe && ad_out == (8'h01 ^ 8'h75), "R6 ram read",
            {ad_oe, ad_out}, {1'b1, 8'h01 ^ 8'h75});
        oer_n = 1'b1; cyc(6);
        chk(!ad_oe, "R6 bus released", ad_oe, 0);

        // R10: power fail
        pwr_fail = 1'b1; cyc(4);
        rf_write(8'h14, 8'h77, 1);
        ram_write(8'h66);
        oer_n = 1'b0; cyc(6);
        chk(!ad_oe, "R10 ram read blocked", ad_oe, 0);
        oer_n = 1'b1; cs_n = 1'b0; rd_n = 1'b0; cyc(6);
        chk(!ad_oe, "R10 rf read blocked", ad_oe, 0);
        rd_n = 1'b1; cs_n = 1'b1;
        pwr_fail = 1'b0; cyc(6);
        rf_write(8'h14, 8'h78, 1);                  // R10 recovery

        cyc(10);
        chk(rf_q.size() == 0 && ram_q.size() == 0, "R3/R5 all writes seen",
            rf_q.size() + ram_q.size(), 0);
        done = 1;
        finish_run();
    end
endmodule